// File: doc/BRIEF.md
# Edge-Filtered Sticky Status Group

This block watches a vector of live status lines and records selected changes on them in a sticky event register. Each clock it samples the lines into a condition register and compares the new sample with the previous one bit by bit. A rising change latches into the event register when the matching bit of the rising-edge filter is 1. A falling change latches when the matching bit of the falling-edge filter is 1. Once set, an event bit stays set until software reads the event register. That read returns the current value and clears the register.

An enable mask chooses which event bits take part in a single summary output. The summary is the OR of the event bits whose mask bit is 1, and it feeds a higher-level status register.

Software reaches the block through a plain register port with a write strobe, a read strobe and a 3-bit address. Read data is combinational from the address. A write or a clearing read takes effect at the clock edge where its strobe is high. The most significant bit of every register is reserved and always reads 0.

Top module: `statreg_group`

## Requirements
- R1: After reset, the condition and event registers are 0, the rising-edge filter is all ones in its usable bits (0x7FFF at the default width), the falling-edge filter is 0, the mask is 0 and `summary` is 0.
- R2: The condition register (address 0) takes the value of `condIn` at every clock edge and keeps no history, so a read returns the input value sampled at the previous edge.
- R3: At the edge where a condition bit goes from 0 to 1 and its rising-edge filter bit (address 2) is 1, the matching event bit (address 1) is set.
- R4: At the edge where a condition bit goes from 1 to 0 and its falling-edge filter bit (address 3) is 1, the matching event bit is set.
- R5: An event bit is never set when no edge passed its filter, including when both filters are 0 or when the edge runs the other way.
- R6: An event bit that is set stays set, even after the condition returns to its earlier value, until the event register is read.
- R7: A read of address 1 returns the current event value, and the event register is 0 after that edge.
- R8: An edge that passes its filter at the same edge as a clearing read is latched and is not lost.
- R9: `summary` is the OR of the event bits ANDed with the mask (address 4), with no register between them, so it changes right after the edge that writes the mask.
- R10: Bit WIDTH-1 always reads 0 in every register, whatever is written or driven on `condIn`.
- R11: The filters and the mask read back the value written to them. Writes to addresses 0, 1 and 5 to 7 change nothing. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| condIn | input | WIDTH | Live status lines |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe; on address 1 it clears the event register |
| regAddr | input | 3 | Register address: 0 condition, 1 event, 2 rising filter, 3 falling filter, 4 mask |
| regWrData | input | WIDTH | Write data |
| regRdData | output | WIDTH | Combinational read data for `regAddr` |
| summary | output | 1 | OR of the enabled event bits |

## Verification
The main function is driven through a table of filter settings and before/after condition pairs. The pairs include rising-only filters, falling-only filters, split filters with edges in both directions, both filters clear, and a change on the reserved top bit. The cases show whether the block tells edge direction apart per bit, whether it ignores unfiltered edges, and whether it masks the reserved bit. Directed cases then cover the case where a condition returns to its old value after an event was set, mask changes seen on `summary`, a clearing read that meets a new edge in the same cycle, and writes to unused addresses.

// File: rtl/statreg_pkg.sv
package statreg_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_COND  = 3'd0,
    ADDR_EVENT = 3'd1,
    ADDR_POS   = 3'd2,
    ADDR_NEG   = 3'd3,
    ADDR_MASK  = 3'd4
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrPos;
    logic wrNeg;
    logic wrMask;
    logic clrEvent;
    logic rdCond;
    logic rdEvent;
    logic rdPos;
    logic rdNeg;
    logic rdMask;
  } strobe_t;

endpackage

// File: rtl/statreg_ctrl.sv
module statreg_ctrl
  import statreg_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobe
);

  logic isCond, isEvent, isPos, isNeg, isMask;

  always_comb begin
    isCond  = (regAddr == ADDR_COND);
    isEvent = (regAddr == ADDR_EVENT);
    isPos   = (regAddr == ADDR_POS);
    isNeg   = (regAddr == ADDR_NEG);
    isMask  = (regAddr == ADDR_MASK);

    strobe.wrPos    = regWrEn & isPos;
    strobe.wrNeg    = regWrEn & isNeg;
    strobe.wrMask   = regWrEn & isMask;
    strobe.clrEvent = regRdEn & isEvent;
    strobe.rdCond   = isCond;
    strobe.rdEvent  = isEvent;
    strobe.rdPos    = isPos;
    strobe.rdNeg    = isNeg;
    strobe.rdMask   = isMask;
  end

endmodule

// File: rtl/statreg_datapath.sv
module statreg_datapath
  import statreg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] condIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] condQ,
  output logic [WIDTH-1:0] eventQ,
  output logic [WIDTH-1:0] posQ,
  output logic [WIDTH-1:0] negQ,
  output logic [WIDTH-1:0] maskQ,
  output logic             summary
);

  localparam int USED_BITS = WIDTH - 1;
  localparam logic [WIDTH-1:0] USED = {1'b0, {USED_BITS{1'b1}}};

  logic [WIDTH-1:0] condLive;
  logic [WIDTH-1:0] edgeHits;
  logic [WIDTH-1:0] eventNext;

  always_comb begin
    condLive  = condIn & USED;
    edgeHits  = (condLive & ~condQ & posQ) | (~condLive & condQ & negQ);
    eventNext = ((strobe.clrEvent ? '0 : eventQ) | edgeHits) & USED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condQ  <= '0;
      eventQ <= '0;
      posQ   <= USED;
      negQ   <= '0;
      maskQ  <= '0;
    end else begin
      condQ  <= condLive;
      eventQ <= eventNext;
      if (strobe.wrPos)  posQ  <= wrData & USED;
      if (strobe.wrNeg)  negQ  <= wrData & USED;
      if (strobe.wrMask) maskQ <= wrData & USED;
    end
  end

  always_comb begin
    rdData = ({WIDTH{strobe.rdCond}}  & condQ)
           | ({WIDTH{strobe.rdEvent}} & eventQ)
           | ({WIDTH{strobe.rdPos}}   & posQ)
           | ({WIDTH{strobe.rdNeg}}   & negQ)
           | ({WIDTH{strobe.rdMask}}  & maskQ);
    summary = |(eventQ & maskQ);
  end

endmodule

// File: rtl/statreg_group.sv
module statreg_group
  import statreg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  condIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  output logic              summary
);

  strobe_t          strobe;
  logic [WIDTH-1:0] condQ, eventQ, posQ, negQ, maskQ;

  statreg_ctrl i_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  statreg_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .condIn  (condIn),
    .rdData  (regRdData),
    .condQ   (condQ),
    .eventQ  (eventQ),
    .posQ    (posQ),
    .negQ    (negQ),
    .maskQ   (maskQ),
    .summary (summary)
  );

endmodule

// File: rtl/statreg_checker.sv
module statreg_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] condIn,
  input logic             regRdEn,
  input logic [2:0]       regAddr,
  input logic [WIDTH-1:0] regRdData,
  input logic             summary,
  input logic [WIDTH-1:0] condQ,
  input logic [WIDTH-1:0] eventQ,
  input logic [WIDTH-1:0] posQ,
  input logic [WIDTH-1:0] negQ,
  input logic [WIDTH-1:0] maskQ
);

  localparam logic [WIDTH-1:0] USED = {1'b0, {(WIDTH-1){1'b1}}};

  logic [WIDTH-1:0] riseHit, fallHit, anyHit;
  logic             clrNow;

  always_comb begin
    riseHit = condIn & USED & ~condQ & posQ;
    fallHit = ~condIn & USED & condQ & negQ;
    anyHit  = riseHit | fallHit;
    clrNow  = regRdEn && (regAddr == 3'd1);
  end

  AST_COND_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (condQ == ($past(condIn) & USED))); // R2
  AST_RISE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(riseHit) & ~eventQ) == '0)); // R3
  AST_FALL_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(fallHit) & ~eventQ) == '0)); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((eventQ & ~$past(eventQ) & ~$past(anyHit)) == '0)); // R5
  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clrNow |=> (($past(eventQ) & ~eventQ) == '0)); // R6
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (clrNow && (anyHit == '0)) |=> (eventQ == '0)); // R7
  AST_EDGE_DURING_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clrNow |=> ((eventQ & ~$past(anyHit)) == '0)); // R8
  AST_SUMMARY_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    summary == |(eventQ & maskQ)); // R9
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[WIDTH-1] == 1'b0) && (eventQ[WIDTH-1] == 1'b0)); // R10

endmodule

bind statreg_group statreg_checker #(.WIDTH(WIDTH)) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .condIn    (condIn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .summary   (summary),
  .condQ     (condQ),
  .eventQ    (eventQ),
  .posQ      (posQ),
  .negQ      (negQ),
  .maskQ     (maskQ)
);

// File: tb/test_statreg_group.sv
module test_statreg_group;

  localparam int W = 16;
  localparam logic [2:0] A_COND = 3'd0, A_EVT = 3'd1, A_POS = 3'd2,
                         A_NEG = 3'd3, A_MASK = 3'd4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] condIn = '0;
  logic         regWrEn = 1'b0;
  logic         regRdEn = 1'b0;
  logic [2:0]   regAddr = '0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  logic         summary;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  statreg_group #(.WIDTH(W)) i_statreg_group (
    .clk(clk), .rstN(rstN), .condIn(condIn), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .summary(summary)
  );

  // pos, neg, condBefore, condAfter, expected event
  typedef struct packed {
    logic [W-1:0] pos;
    logic [W-1:0] neg;
    logic [W-1:0] condA;
    logic [W-1:0] condB;
    logic [W-1:0] expEvt;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 16'h0000, 16'h0000, 16'h00F0, 16'h00F0},
    '{16'h0000, 16'hFFFF, 16'h0F0F, 16'h0F00, 16'h000F},
    '{16'h00FF, 16'hFF00, 16'h0F0F, 16'hF0F0, 16'h0FF0},
    '{16'hFFFF, 16'hFFFF, 16'h8000, 16'h0001, 16'h0001},
    '{16'h0000, 16'h0000, 16'h1234, 16'hEDCB, 16'h0000},
    '{16'hA5A5, 16'h5A5A, 16'h0000, 16'hFFFF, 16'h25A5}
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic setCond(input logic [W-1:0] c);
    @(negedge clk);
    condIn = c;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic [W-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1 check("R1 summary", {15'd0, summary}, 16'h0000);
    readReg(A_POS, rd);  check("R1 pos", rd, 16'h7FFF);
    readReg(A_NEG, rd);  check("R1 neg", rd, 16'h0000);
    readReg(A_MASK, rd); check("R1 mask", rd, 16'h0000);
    readReg(A_COND, rd); check("R1 cond", rd, 16'h0000);
    readReg(A_EVT, rd);  check("R1 event", rd, 16'h0000);

    // table walk: R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      writeReg(A_POS, VECS[i].pos);
      writeReg(A_NEG, VECS[i].neg);
      setCond(VECS[i].condA);
      readReg(A_EVT, rd);
      setCond(VECS[i].condB);
      readReg(A_EVT, rd);
      check("R3/R4/R5 table", rd, VECS[i].expEvt);
    end

    // R2 condition follows input, R10 top bit
    setCond(16'h1234);
    readReg(A_COND, rd); check("R2 cond", rd, 16'h1234);
    setCond(16'hFFFF);
    readReg(A_COND, rd); check("R10 cond top bit", rd, 16'h7FFF);

    // R6 sticky
    writeReg(A_POS, 16'hFFFF);
    writeReg(A_NEG, 16'h0000);
    setCond(16'h0000);
    readReg(A_EVT, rd);
    setCond(16'h0002);
    setCond(16'h0000);
    @(negedge clk);
    // R9 summary blocked by mask 0
    #1 check("R9 summary masked", {15'd0, summary}, 16'h0000);
    writeReg(A_MASK, 16'h0002);
    #1 check("R9 summary enabled", {15'd0, summary}, 16'h0001);
    writeReg(A_MASK, 16'h0004);
    #1 check("R9 summary other bit", {15'd0, summary}, 16'h0000);
    readReg(A_EVT, rd); check("R6 sticky", rd, 16'h0002);
    readReg(A_EVT, rd); check("R7 cleared", rd, 16'h0000);

    // R8 edge during clearing read
    setCond(16'h0001);
    @(negedge clk);
    condIn = 16'h0011; regRdEn = 1'b1; regAddr = A_EVT;
    #1 check("R7 read value", regRdData, 16'h0001);
    @(negedge clk);
    regRdEn = 1'b0;
    readReg(A_EVT, rd); check("R8 edge kept", rd, 16'h0010);

    // R11 readback and ignored addresses
    writeReg(A_NEG, 16'h1234);
    writeReg(A_MASK, 16'h00F0);
    writeReg(3'd7, 16'hFFFF);
    writeReg(A_COND, 16'hFFFF);
    writeReg(A_EVT, 16'hFFFF);
    readReg(A_NEG, rd);  check("R11 neg", rd, 16'h1234);
    readReg(A_MASK, rd); check("R11 mask", rd, 16'h00F0);
    readReg(A_POS, rd);  check("R11 pos", rd, 16'h7FFF);
    readReg(A_EVT, rd);  check("R11 event untouched", rd, 16'h0000);
    readReg(A_COND, rd); check("R11 cond untouched", rd, 16'h0011);
    readReg(3'd5, rd);   check("R11 unused read", rd, 16'h0000);
    writeReg(A_MASK, 16'hFFFF);
    readReg(A_MASK, rd); check("R10 mask top bit", rd, 16'h7FFF);

    finishRun();
  end

endmodule